// File: doc/BRIEF.md
# Call and Return Frame Controller

This block owns the three frame indices of a stack-oriented execution core: the fetch address, the base of the current local frame, and the index of the stack top. A call saves the address of the instruction after the call and the caller's frame base in a small on-chip link cache. It then moves the frame base down so that the arguments already pushed become the callee's first locals, and it jumps. A return pops the saved pair and places the stack top so that the callee's results sit on the caller's stack. The global frame pointer is not part of this block. Neither frame index is written from anywhere else.

One operation is presented per cycle on `op_code`. The new state is visible on the outputs after the next rising clock edge. When a call finds the link cache full, or a return finds it empty, the operation is dropped whole. A fault flag is then raised for exactly one cycle.

Top module: `frame_ctl`

## Requirements
- R1: After reset, `fetch_addr` equals RESET_ADDR (default 0x100), `frame_base` is 1, `stack_ptr` is 0, `link_depth` is 0, and both fault outputs are low.
- R2: With op_code 1 (step), `fetch_addr` grows by `instr_len` bytes (1 to 5) at the next edge, and the frame and stack indices are unchanged.
- R3: With op_code 2 (direct call) and the cache not full, the next state has `fetch_addr` = `jump_target`, `frame_base` = S + 1 − `arg_count` (S is the stack top before the call), and `stack_ptr` unchanged. `link_depth` rises by one.
- R4: With op_code 3 (call through the stack top) and the cache not full, the target slot is consumed first. `stack_ptr` becomes S − 1, `frame_base` becomes S − `arg_count`, and `fetch_addr` becomes `tos_value`. `link_depth` rises by one.
- R5: With op_code 4 (return) and the cache not empty, `fetch_addr` returns to the calling instruction's address plus its `instr_len`, and `frame_base` returns to the caller's value. `stack_ptr` becomes the callee's frame base − 1 + `arg_count`, where `arg_count` is the result count. `link_depth` falls by one.
- R6: Nested calls are undone last-in first-out: each return restores the pair saved by the most recent unreturned call.
- R7: A call (op_code 2 or 3) while `link_depth` equals DEPTH leaves every index and the depth unchanged. It drives `fault_overflow` high for exactly the following cycle.
- R8: A return while `link_depth` is 0 leaves every index unchanged and drives `fault_underflow` high for exactly the following cycle.
- R9: With op_code 5 (stack adjust), `stack_ptr` moves by `stack_delta`, read as a 4-bit two's complement value, and the other state holds.
- R10: With op_code 0 (idle), all state holds. The frame and stack indices wrap modulo 2^IDX_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_code | input | 3 | Operation: 0 idle, 1 step, 2 direct call, 3 stack call, 4 return, 5 stack adjust |
| instr_len | input | 3 | Byte length of the current instruction |
| jump_target | input | ADDR_W | Immediate byte address for a direct call |
| tos_value | input | ADDR_W | Value held in the stack-top slot, target of a stack call |
| arg_count | input | CNT_W | Argument count on calls, result count on returns |
| stack_delta | input | 4 | Signed stack-top adjustment |
| fetch_addr | output | ADDR_W | Current instruction byte address |
| frame_base | output | IDX_W | Index of the first local of the current frame |
| stack_ptr | output | IDX_W | Index of the stack top |
| link_depth | output | $clog2(DEPTH+1) | Number of saved call links |
| fault_overflow | output | 1 | One-cycle pulse: call refused, cache full |
| fault_underflow | output | 1 | One-cycle pulse: return refused, cache empty |

## Verification
The bench builds the block with DEPTH = 4 and IDX_W = 6 and keeps the 32-bit address width. A four-deep cache reaches overflow after a handful of nested calls, and draining it to underflow takes only as many returns. The narrow index lets a single negative stack adjustment from reset carry the stack top across the wrap boundary. Nested calls mix direct and stack-sourced targets with differing argument counts. This shows that the saved pairs come back in reverse order.

// File: rtl/frame_pkg.sv
package frame_pkg;

  typedef enum logic [2:0] {
    OP_IDLE     = 3'd0,
    OP_STEP     = 3'd1,
    OP_CALL_DIR = 3'd2,
    OP_CALL_TOS = 3'd3,
    OP_RETURN   = 3'd4,
    OP_ADJ_S    = 3'd5
  } frame_op_e;

  localparam int LEN_W   = 3;
  localparam int DELTA_W = 4;

endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/ret_cache.sv
module ret_cache #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int DEPTH  = 8,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [IDX_W-1:0]  push_base,
  output logic [ADDR_W-1:0] top_addr,
  output logic [IDX_W-1:0]  top_base,
  output logic [LVL_W-1:0]  level,
  output logic              full,
  output logic              empty
);

  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] LVL_ONE = 1;

  logic [ADDR_W-1:0] slot_addr [DEPTH];
  logic [IDX_W-1:0]  slot_base [DEPTH];
  logic [LVL_W-1:0]  level_d;
  logic [LVL_W-1:0]  level_m1;
  logic [PTR_W-1:0]  rd_ptr;

  assign full     = (level == LVL_MAX);
  assign empty    = (level == '0);
  assign level_m1 = level - LVL_ONE;
  assign rd_ptr   = level_m1[PTR_W-1:0];

  // Storage slots: written only, never reset
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic wr_en;
    assign wr_en = push && (level == LVL_W'(g));
    always_ff @(posedge clk) begin
      if (wr_en) begin
        slot_addr[g] <= push_addr;
        slot_base[g] <= push_base;
      end
    end
  end

  always_comb begin
    top_addr = '0;
    top_base = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_ptr == PTR_W'(i)) begin
        top_addr = slot_addr[i];
        top_base = slot_base[i];
      end
    end
  end

  always_comb begin
    level_d = level;
    if (push && !full)      level_d = level + LVL_ONE;
    else if (pop && !empty) level_d = level - LVL_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            level <= '0;
    else if (push || pop)  level <= level_d;
  end

  AST_LEVEL_BOUND:  assert property (@(posedge clk) disable iff (!rst_n) level <= LVL_MAX);                        // R7
  AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(push && pop));                       // R6
  AST_PUSH_GROWS:   assert property (@(posedge clk) disable iff (!rst_n) push |=> level == $past(level) + LVL_ONE); // R6
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);                        // R8

endmodule

// File: rtl/frame_next.sv
module frame_next
  import frame_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int CNT_W  = 4
) (
  input  frame_op_e                 op,
  input  logic [LEN_W-1:0]          instr_len,
  input  logic [ADDR_W-1:0]         jump_target,
  input  logic [ADDR_W-1:0]         tos_value,
  input  logic [CNT_W-1:0]          arg_count,
  input  logic [DELTA_W-1:0]        stack_delta,
  input  logic [ADDR_W-1:0]         cur_addr,
  input  logic [IDX_W-1:0]          cur_base,
  input  logic [IDX_W-1:0]          cur_sp,
  input  logic [ADDR_W-1:0]         top_addr,
  input  logic [IDX_W-1:0]          top_base,
  input  logic                      full,
  input  logic                      empty,
  output logic [ADDR_W-1:0]         nxt_addr,
  output logic [IDX_W-1:0]          nxt_base,
  output logic [IDX_W-1:0]          nxt_sp,
  output logic [ADDR_W-1:0]         link_addr,
  output logic                      push,
  output logic                      pop,
  output logic                      ovf,
  output logic                      unf,
  output logic                      upd
);

  localparam logic [IDX_W-1:0] ONE_IDX = 1;

  logic [ADDR_W-1:0] len_ext;
  logic [IDX_W-1:0]  cnt_ext;
  logic [IDX_W-1:0]  delta_ext;

  assign len_ext   = {{(ADDR_W-LEN_W){1'b0}}, instr_len};
  assign cnt_ext   = {{(IDX_W-CNT_W){1'b0}}, arg_count};
  assign delta_ext = {{(IDX_W-DELTA_W){stack_delta[DELTA_W-1]}}, stack_delta};
  assign link_addr = cur_addr + len_ext;

  always_comb begin
    nxt_addr = cur_addr;
    nxt_base = cur_base;
    nxt_sp   = cur_sp;
    push     = 1'b0;
    pop      = 1'b0;
    ovf      = 1'b0;
    unf      = 1'b0;
    unique case (op)
      OP_STEP: nxt_addr = link_addr;
      OP_CALL_DIR: begin
        if (full) ovf = 1'b1;
        else begin
          push     = 1'b1;
          nxt_addr = jump_target;
          nxt_base = cur_sp + ONE_IDX - cnt_ext;
        end
      end
      OP_CALL_TOS: begin
        if (full) ovf = 1'b1;
        else begin
          push     = 1'b1;
          nxt_addr = tos_value;
          nxt_sp   = cur_sp - ONE_IDX;
          nxt_base = cur_sp - cnt_ext;
        end
      end
      OP_RETURN: begin
        if (empty) unf = 1'b1;
        else begin
          pop      = 1'b1;
          nxt_addr = top_addr;
          nxt_base = top_base;
          nxt_sp   = cur_base - ONE_IDX + cnt_ext;
        end
      end
      OP_ADJ_S: nxt_sp = cur_sp + delta_ext;
      default: ;
    endcase
    upd = (op != OP_IDLE) && !ovf && !unf;
  end

endmodule

// File: rtl/frame_ctl.sv
module frame_ctl
  import frame_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter int              IDX_W      = 8,
  parameter int              CNT_W      = 4,
  parameter int              DEPTH      = 8,
  parameter logic [31:0]     RESET_ADDR = 32'h0000_0100,
  localparam int             LVL_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_code,
  input  logic [2:0]        instr_len,
  input  logic [ADDR_W-1:0] jump_target,
  input  logic [ADDR_W-1:0] tos_value,
  input  logic [CNT_W-1:0]  arg_count,
  input  logic [3:0]        stack_delta,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [IDX_W-1:0]  frame_base,
  output logic [IDX_W-1:0]  stack_ptr,
  output logic [LVL_W-1:0]  link_depth,
  output logic              fault_overflow,
  output logic              fault_underflow
);

  localparam logic [IDX_W-1:0] ONE_IDX    = 1;
  localparam logic [IDX_W-1:0] BASE_RESET = 1;
  localparam logic [IDX_W-1:0] SP_RESET   = 0;

  logic              rst_n_sync;
  frame_op_e         op;
  logic [ADDR_W-1:0] nxt_addr, link_addr, top_addr;
  logic [IDX_W-1:0]  nxt_base, nxt_sp, top_base;
  logic              push, pop, ovf, unf, upd, full, empty;
  logic [IDX_W-1:0]  cnt_w;
  logic [ADDR_W-1:0] len_w;

  assign op    = frame_op_e'(op_code);
  assign cnt_w = {{(IDX_W-CNT_W){1'b0}}, arg_count};
  assign len_w = {{(ADDR_W-3){1'b0}}, instr_len};

  rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  frame_next #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_next (
    .op          (op),
    .instr_len   (instr_len),
    .jump_target (jump_target),
    .tos_value   (tos_value),
    .arg_count   (arg_count),
    .stack_delta (stack_delta),
    .cur_addr    (fetch_addr),
    .cur_base    (frame_base),
    .cur_sp      (stack_ptr),
    .top_addr    (top_addr),
    .top_base    (top_base),
    .full        (full),
    .empty       (empty),
    .nxt_addr    (nxt_addr),
    .nxt_base    (nxt_base),
    .nxt_sp      (nxt_sp),
    .link_addr   (link_addr),
    .push        (push),
    .pop         (pop),
    .ovf         (ovf),
    .unf         (unf),
    .upd         (upd)
  );

  ret_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DEPTH(DEPTH)) u_cache (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .push      (push),
    .pop       (pop),
    .push_addr (link_addr),
    .push_base (frame_base),
    .top_addr  (top_addr),
    .top_base  (top_base),
    .level     (link_depth),
    .full      (full),
    .empty     (empty)
  );

  // Frame state registers, written only when an operation is accepted
  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      fetch_addr <= RESET_ADDR[ADDR_W-1:0];
      frame_base <= BASE_RESET;
      stack_ptr  <= SP_RESET;
    end else if (upd) begin
      fetch_addr <= nxt_addr;
      frame_base <= nxt_base;
      stack_ptr  <= nxt_sp;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      fault_overflow  <= 1'b0;
      fault_underflow <= 1'b0;
    end else begin
      fault_overflow  <= ovf;
      fault_underflow <= unf;
    end
  end

  AST_STEP_ADDR:  assert property (@(posedge clk) disable iff (!rst_n_sync)
    op_code == 3'd1 |=> fetch_addr == $past(fetch_addr) + $past(len_w));                                   // R2
  AST_CALL_TARGET: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (op_code == 3'd2 && !full) |=> fetch_addr == $past(jump_target));                                     // R3
  AST_CALL_BASE:  assert property (@(posedge clk) disable iff (!rst_n_sync)
    (op_code == 3'd2 && !full) |=> frame_base == $past(stack_ptr) + ONE_IDX - $past(cnt_w));               // R3
  AST_TOS_CALL:   assert property (@(posedge clk) disable iff (!rst_n_sync)
    (op_code == 3'd3 && !full) |=> stack_ptr == $past(stack_ptr) - ONE_IDX && fetch_addr == $past(tos_value)); // R4
  AST_RET_SP:     assert property (@(posedge clk) disable iff (!rst_n_sync)
    (op_code == 3'd4 && !empty) |=> stack_ptr == $past(frame_base) - ONE_IDX + $past(cnt_w));              // R5
  AST_RET_LINK:   assert property (@(posedge clk) disable iff (!rst_n_sync)
    (op_code == 3'd4 && !empty) |=> fetch_addr == $past(top_addr) && frame_base == $past(top_base));        // R6
  AST_OVF_HOLD:   assert property (@(posedge clk) disable iff (!rst_n_sync)
    ((op_code == 3'd2 || op_code == 3'd3) && full) |=> fault_overflow && $stable(fetch_addr) && $stable(frame_base) && $stable(stack_ptr)); // R7
  AST_UNF_HOLD:   assert property (@(posedge clk) disable iff (!rst_n_sync)
    (op_code == 3'd4 && empty) |=> fault_underflow && $stable(fetch_addr) && $stable(frame_base) && $stable(stack_ptr)); // R8
  AST_ADJ_HOLD:   assert property (@(posedge clk) disable iff (!rst_n_sync)
    op_code == 3'd5 |=> $stable(fetch_addr) && $stable(frame_base));                                      // R9
  AST_IDLE_HOLD:  assert property (@(posedge clk) disable iff (!rst_n_sync)
    op_code == 3'd0 |=> $stable(fetch_addr) && $stable(frame_base) && $stable(stack_ptr) && $stable(link_depth)); // R10

endmodule

// File: tb/frame_ctl_test.sv
module frame_ctl_test;

  localparam int AW  = 32;
  localparam int IW  = 6;
  localparam int CW  = 4;
  localparam int DEP = 4;
  localparam int LW  = $clog2(DEP + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    op_code = '0;
  logic [2:0]    instr_len = '0;
  logic [AW-1:0] jump_target = '0;
  logic [AW-1:0] tos_value = '0;
  logic [CW-1:0] arg_count = '0;
  logic [3:0]    stack_delta = '0;
  logic [AW-1:0] fetch_addr;
  logic [IW-1:0] frame_base, stack_ptr;
  logic [LW-1:0] link_depth;
  logic          fault_overflow, fault_underflow;

  int checks = 0;
  int errors = 0;

  logic [AW-1:0] m_pc;
  logic [IW-1:0] m_l, m_s;
  int            m_lvl;
  logic [AW-1:0] m_spc [DEP];
  logic [IW-1:0] m_sl  [DEP];
  logic          m_ovf, m_unf;

  always #4 clk = ~clk;

  frame_ctl #(.ADDR_W(AW), .IDX_W(IW), .CNT_W(CW), .DEPTH(DEP)) uut (
    .clk, .rst_n, .op_code, .instr_len, .jump_target, .tos_value, .arg_count,
    .stack_delta, .fetch_addr, .frame_base, .stack_ptr, .link_depth,
    .fault_overflow, .fault_underflow
  );

  task automatic chk(input string tag, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "addr",  fetch_addr, m_pc);
    chk(tag, "base",  AW'(frame_base), AW'(m_l));
    chk(tag, "sp",    AW'(stack_ptr), AW'(m_s));
    chk(tag, "depth", AW'(link_depth), AW'(m_lvl));
    chk(tag, "ovf",   AW'(fault_overflow), AW'(m_ovf));
    chk(tag, "unf",   AW'(fault_underflow), AW'(m_unf));
  endtask

  // Apply one operation, update the model from the requirements, then check
  task automatic do_op(input string tag, input logic [2:0] op, input logic [2:0] len,
                       input logic [AW-1:0] tgt, input logic [AW-1:0] tos,
                       input logic [CW-1:0] cnt, input logic [3:0] dlt);
    op_code = op; instr_len = len; jump_target = tgt; tos_value = tos;
    arg_count = cnt; stack_delta = dlt;
    m_ovf = 1'b0; m_unf = 1'b0;
    case (op)
      3'd1: m_pc = m_pc + AW'(len);
      3'd2, 3'd3: begin
        if (m_lvl == DEP) m_ovf = 1'b1;
        else begin
          m_spc[m_lvl] = m_pc + AW'(len);
          m_sl[m_lvl]  = m_l;
          m_lvl++;
          if (op == 3'd3) begin
            m_s  = m_s - IW'(1);
            m_pc = tos;
          end else m_pc = tgt;
          m_l = m_s + IW'(1) - IW'(cnt);
        end
      end
      3'd4: begin
        if (m_lvl == 0) m_unf = 1'b1;
        else begin
          m_lvl--;
          m_s  = m_l - IW'(1) + IW'(cnt);
          m_pc = m_spc[m_lvl];
          m_l  = m_sl[m_lvl];
        end
      end
      3'd5: m_s = m_s + {{(IW-4){dlt[3]}}, dlt};
      default: ;
    endcase
    @(posedge clk);
    @(negedge clk);
    op_code = 3'd0;
    chk_all(tag);
  endtask

  task automatic t_reset();
    m_pc = 32'h100; m_l = 1; m_s = 0; m_lvl = 0; m_ovf = 0; m_unf = 0;
    chk_all("R1");
  endtask

  task automatic t_step();
    do_op("R2", 3'd1, 3'd1, '0, '0, '0, '0);
    do_op("R2", 3'd1, 3'd2, '0, '0, '0, '0);
    do_op("R2", 3'd1, 3'd5, '0, '0, '0, '0);
  endtask

  task automatic t_adjust_and_wrap();
    do_op("R9", 3'd5, 3'd0, '0, '0, '0, 4'hF);     // -1 from 0 wraps to 63
    chk("R10", "wrap", AW'(stack_ptr), 32'd63);
    do_op("R9", 3'd5, 3'd0, '0, '0, '0, 4'd7);
    do_op("R9", 3'd5, 3'd0, '0, '0, '0, 4'd4);     // now 10
    do_op("R10", 3'd0, 3'd3, 32'hDEAD, 32'hBEEF, 4'd3, 4'd5);
  endtask

  task automatic t_call_ret();
    do_op("R3", 3'd2, 3'd3, 32'h0000_1000, '0, 4'd2, '0);
    do_op("R2", 3'd1, 3'd2, '0, '0, '0, '0);
    do_op("R9", 3'd5, 3'd0, '0, '0, '0, 4'd3);
    do_op("R5", 3'd4, 3'd1, '0, '0, 4'd1, '0);
    do_op("R4", 3'd3, 3'd1, '0, 32'h2000_0040, 4'd1, '0);
    do_op("R5", 3'd4, 3'd1, '0, '0, 4'd0, '0);
  endtask

  task automatic t_nest_faults();
    do_op("R6", 3'd2, 3'd5, 32'h0000_3000, '0, 4'd0, '0);
    do_op("R6", 3'd3, 3'd1, '0, 32'h0000_4100, 4'd1, '0);
    do_op("R6", 3'd5, 3'd0, '0, '0, '0, 4'd2);
    do_op("R6", 3'd2, 3'd2, 32'h0000_5200, '0, 4'd3, '0);
    do_op("R6", 3'd2, 3'd3, 32'h0000_6300, '0, 4'd2, '0);
    do_op("R7", 3'd2, 3'd3, 32'h0000_7000, '0, 4'd1, '0);
    do_op("R7", 3'd3, 3'd1, '0, 32'h0000_7700, 4'd1, '0);
    do_op("R7", 3'd0, 3'd0, '0, '0, '0, '0);       // pulse gone
    for (int i = 0; i < DEP; i++) do_op("R6", 3'd4, 3'd1, '0, '0, CW'(i), '0);
    do_op("R8", 3'd4, 3'd1, '0, '0, 4'd2, '0);
    do_op("R8", 3'd1, 3'd1, '0, '0, '0, '0);       // pulse gone, step still works
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_step();
    t_adjust_and_wrap();
    t_call_ret();
    t_nest_faults();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule